// File: doc/BRIEF.md
# 8-bit Timer/Counter with Shared Prescaler

This block is an 8-bit up-counter that advances from one of two tick sources. In timer mode the tick is one system clock in every four, so each tick stands for one instruction cycle. In counter mode the tick is an edge on an asynchronous external pin, with the active edge chosen by a configuration bit. Either tick stream can be passed through a power-of-two prescaler before it reaches the count, or can bypass it when the prescaler is handed to another user.

Software loads the count through a write strobe and reads it back at any time. A write also empties the prescaler, so the next increment is a full prescaled period away. When the count wraps from its top value to zero, a one-clock overflow pulse goes to the interrupt logic. Storing that pulse as a flag is left to the consumer.

Top module: `tick_counter8`

## Requirements
- R1: When reset is released, the count reads 00h, the overflow output is low, and the prescaler count is zero.
- R2: With the mode input at 0 (timer mode) and the bypass input at 1, the count rises by one every 4 clock cycles.
- R3: With the bypass input at 0, the 3-bit ratio code k divides the tick stream by 2^(k+1), from 1:2 at code 000 to 1:256 at code 111. In timer mode, increments are then 4·2^(k+1) clocks apart.
- R4: With the mode input at 1 (counter mode), the external pin passes through a two-stage synchronizer, and each edge of the selected polarity adds one tick: rising edges when the edge input is 0, falling edges when it is 1. Edges of the other polarity leave the count unchanged.
- R5: In counter mode, the internal divide-by-four cycle never changes the count while the pin is idle.
- R6: The prescaler divides the external edge stream in counter mode just as it divides the timer stream.
- R7: A write strobe loads the write data into the count at the next clock edge, takes priority over any increment in that cycle, and clears the prescaler. In timer mode with period P, the first increment after a write therefore arrives no sooner than P−3 and no later than P clocks after the write edge.
- R8: The overflow output is high for exactly one clock, in the cycle in which the count has just wrapped from FFh to 00h, and is low at every other time.
- R9: Apart from a write, the count changes only by +1 (modulo 256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_i | input | 1 | Asynchronous external count input |
| mode_ext_i | input | 1 | 0 = timer (clock/4), 1 = external edge counter |
| edge_fall_i | input | 1 | 0 = count rising edges, 1 = count falling edges |
| psc_bypass_i | input | 1 | 1 = prescaler assigned elsewhere; ticks go straight to the count |
| psc_ratio_i | input | 3 | Prescaler code k, divide by 2^(k+1) |
| wr_en_i | input | 1 | Software write strobe for the count |
| wr_data_i | input | 8 | Value loaded on a write |
| count_o | output | 8 | Current count |
| ovf_o | output | 1 | One-clock pulse on wrap from FFh to 00h |

## Verification
The bench sweeps all eight ratio codes and the bypass path. For each setting it measures the spacing of every increment, and it checks the delay from a write to the first increment. A prescaler that misdecodes its code shows up as a wrong spacing. A write that fails to clear the prescaler makes the first increment arrive early. The bench toggles the pin one polarity at a time in both edge settings, so an inverted edge select or a missing edge qualifier is caught. It also checks that the idle pin leaves the count unchanged in counter mode. Across the FFh to 00h wrap it counts the overflow pulses, so a pulse that is missing, doubled, or placed on the wrong cycle fails the check.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned CNT_W_DEF   = 8;
    localparam int unsigned RATIO_W_DEF = 3;
    localparam int unsigned PHASE_W_DEF = 2;
    localparam int unsigned SYNC_N_DEF  = 2;

    typedef enum logic {
        SRC_TIMER = 1'b0,
        SRC_PIN   = 1'b1
    } tick_src_e;
endpackage

// File: rtl/tmr_tick_src.sv
module tmr_tick_src #(
    parameter int unsigned PHASE_W = tmr_pkg::PHASE_W_DEF,
    parameter int unsigned SYNC_N  = tmr_pkg::SYNC_N_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic mode_ext_i,
    input  logic edge_fall_i,
    output logic tick_o
);
    localparam int unsigned SH_W = SYNC_N + 1;

    typedef struct packed {
        logic [SH_W-1:0]    shift;
        logic [PHASE_W-1:0] phase;
    } state_t;

    state_t st_d, st_q;
    logic   cur_lvl, prev_lvl, rise, fall, pin_tick;
    tmr_pkg::tick_src_e src;

    always_comb begin
        st_d       = st_q;
        st_d.shift = {st_q.shift[SH_W-2:0], pin_i};
        st_d.phase = st_q.phase + PHASE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_lvl  = st_q.shift[SYNC_N-1];
    assign prev_lvl = st_q.shift[SYNC_N];
    assign rise     = cur_lvl & ~prev_lvl;
    assign fall     = ~cur_lvl & prev_lvl;
    assign pin_tick = edge_fall_i ? fall : rise;
    assign src      = tmr_pkg::tick_src_e'(mode_ext_i);
    assign tick_o   = (src == tmr_pkg::SRC_PIN) ? pin_tick : (st_q.phase == '1);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned RATIO_W = tmr_pkg::RATIO_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               bypass_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               clr_i,
    output logic               tick_o
);
    localparam int unsigned PSC_W = 1 << RATIO_W;

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } state_t;

    state_t           st_d, st_q;
    logic [PSC_W-1:0] limit;
    logic             at_limit;

    assign limit    = (PSC_W'(2) << ratio_i) - PSC_W'(1);
    assign at_limit = (st_q.cnt == limit);

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.cnt = '0;
        else if (tick_i && !bypass_i)
            st_d.cnt = at_limit ? '0 : st_q.cnt + PSC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = bypass_i ? tick_i : (tick_i & at_limit);
endmodule

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
    parameter int unsigned CNT_W = tmr_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             ovf;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (wr_i) begin
            st_d.count = wr_data_i;
        end else if (inc_i) begin
            st_d.count = st_q.count + CNT_W'(1);
            st_d.ovf   = (st_q.count == '1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign ovf_o   = st_q.ovf;
endmodule

// File: rtl/tick_counter8.sv
module tick_counter8 #(
    parameter int unsigned CNT_W   = tmr_pkg::CNT_W_DEF,
    parameter int unsigned RATIO_W = tmr_pkg::RATIO_W_DEF,
    parameter int unsigned PHASE_W = tmr_pkg::PHASE_W_DEF,
    parameter int unsigned SYNC_N  = tmr_pkg::SYNC_N_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_pin_i,
    input  logic               mode_ext_i,
    input  logic               edge_fall_i,
    input  logic               psc_bypass_i,
    input  logic [RATIO_W-1:0] psc_ratio_i,
    input  logic               wr_en_i,
    input  logic [CNT_W-1:0]   wr_data_i,
    output logic [CNT_W-1:0]   count_o,
    output logic               ovf_o
);
    logic raw_tick;
    logic cnt_tick;

    tmr_tick_src #(.PHASE_W(PHASE_W), .SYNC_N(SYNC_N)) u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (ext_pin_i),
        .mode_ext_i  (mode_ext_i),
        .edge_fall_i (edge_fall_i),
        .tick_o      (raw_tick)
    );

    tmr_prescale #(.RATIO_W(RATIO_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (raw_tick),
        .bypass_i (psc_bypass_i),
        .ratio_i  (psc_ratio_i),
        .clr_i    (wr_en_i),
        .tick_o   (cnt_tick)
    );

    tmr_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (cnt_tick),
        .wr_i      (wr_en_i),
        .wr_data_i (wr_data_i),
        .count_o   (count_o),
        .ovf_o     (ovf_o)
    );
endmodule

// File: rtl/tick_counter8_chk.sv
module tick_counter8_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_o
);
    // R8: pulse lasts one clock
    a_r8_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);

    // R8: pulse only with a zero count
    a_r8_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (count_o == '0));

    // R8: pulse only after the top value
    a_r8_ovf_after_top: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> ($past(count_o) == '1));

    // R7: write lands on the next edge
    a_r7_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (count_o == $past(wr_data_i)));

    // R9: no jumps other than +1
    a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((count_o == $past(count_o)) ||
                      ((count_o - $past(count_o)) == CNT_W'(1))));
endmodule

bind tick_counter8 tick_counter8_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .ovf_o     (ovf_o)
);

// File: tb/tick_counter8_tb.sv
`timescale 1ns/1ps
module tick_counter8_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic       mode_ext = 1'b0;
    logic       edge_fall = 1'b0;
    logic       bypass = 1'b1;
    logic [2:0] ratio = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] count;
    logic       ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tick_counter8 u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_pin_i    (ext_pin),
        .mode_ext_i   (mode_ext),
        .edge_fall_i  (edge_fall),
        .psc_bypass_i (bypass),
        .psc_ratio_i  (ratio),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .count_o      (count),
        .ovf_o        (ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        step();
        wr_en   = 1'b0;
    endtask

    // Timer-mode period sweep; covers R2, R3, R7, R9
    task automatic measure(input bit byp, input logic [2:0] code);
        int p, last, changes;
        logic [7:0] prev;
        mode_ext = 1'b0;
        bypass   = byp;
        ratio    = code;
        step();
        do_write(8'h00);
        p       = byp ? 4 : (4 << (code + 1));
        prev    = 8'h00;
        last    = 0;
        changes = 0;
        for (int k = 1; k <= 4 * p + 4 && changes < 3; k++) begin
            step();
            if (count != prev) begin
                changes++;
                chk(count == prev + 8'd1, "R9 step", count, prev + 1);
                if (changes == 1)
                    chk(k >= p - 3 && k <= p, byp ? "R2/R7 first" : "R7 first after write", k, p);
                else
                    chk(k - last == p, byp ? "R2 period" : "R3 period", k - last, p);
                last = k;
                prev = count;
            end
        end
        chk(changes == 3, "R3 increments seen", changes, 3);
    endtask

    task automatic pin_to(input logic v);
        ext_pin = v;
        repeat (6) step();
    endtask

    initial begin
        int pulses;
        bit seen_zero;
        repeat (3) step();
        chk(count == 8'h00, "R1 reset count", count, 0);
        chk(ovf == 1'b0, "R1 reset ovf", ovf, 0);
        rst_n = 1'b1;
        step();

        measure(1'b1, 3'd0);
        for (int c = 0; c < 8; c++) measure(1'b0, 3'(c));

        // R5: counter mode, idle pin
        mode_ext = 1'b1; bypass = 1'b1; edge_fall = 1'b0;
        ext_pin = 1'b0;
        step();
        do_write(8'hA5);
        chk(count == 8'hA5, "R7 load", count, 8'hA5);
        repeat (20) step();
        chk(count == 8'hA5, "R5 idle pin", count, 8'hA5);

        // R4 rising select
        do_write(8'h00);
        pin_to(1'b1);
        chk(count == 8'd1, "R4 rising counted", count, 1);
        pin_to(1'b0);
        chk(count == 8'd1, "R4 falling ignored", count, 1);

        // R4 falling select
        edge_fall = 1'b1;
        step();
        do_write(8'h00);
        pin_to(1'b1);
        chk(count == 8'd0, "R4 rising ignored", count, 0);
        pin_to(1'b0);
        chk(count == 8'd1, "R4 falling counted", count, 1);

        // R4 several rising pulses
        edge_fall = 1'b0;
        step();
        do_write(8'h00);
        for (int i = 0; i < 5; i++) begin pin_to(1'b1); pin_to(1'b0); end
        chk(count == 8'd5, "R4 pulse train", count, 5);

        // R6 prescaler 1:4 on pin edges
        bypass = 1'b0; ratio = 3'd1;
        step();
        do_write(8'h00);
        for (int i = 0; i < 8; i++) begin pin_to(1'b1); pin_to(1'b0); end
        chk(count == 8'd2, "R6 pin prescaled", count, 2);

        // R8 overflow around wrap
        mode_ext = 1'b0; bypass = 1'b1;
        step();
        do_write(8'hFD);
        pulses = 0; seen_zero = 1'b0;
        for (int i = 0; i < 24; i++) begin
            step();
            if (ovf) begin
                pulses++;
                chk(count == 8'h00, "R8 ovf with zero", count, 0);
            end
            if (count == 8'h00 && !seen_zero) begin
                seen_zero = 1'b1;
                chk(ovf == 1'b1, "R8 ovf on wrap", ovf, 1);
            end
        end
        chk(pulses == 1, "R8 single pulse", pulses, 1);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule